// File: doc/BRIEF.md
# Temperature limit event generator

This block sits behind a temperature converter and turns each recorded 13-bit two's-complement sample into trip status bits and an alarm output. It has a critical limit, a high limit and a low limit. Each one has a status bit that sets when its limit is crossed and releases at a point lowered by a programmable hysteresis offset. The alarm output can follow the high/low window level (comparator behaviour). It can latch every window crossing until software clears it (interrupt behaviour). It can also respond only to the critical limit. A clear issued while the critical bit is set is held and carried out when that bit releases.

The limits and all configuration fields come from registers outside the block. The block re-evaluates its conditions on an accepted sample and on a limit-write strobe. Changes on the limit inputs at any other time have no effect until the next evaluation. A shutdown input freezes the held sample, the status bits and the interrupt latch. The alarm pin is presented as a pull-down enable for an open-drain driver, with selectable polarity and an enable.

Top module: `tempEventGen`

## Requirements
- R1: The sample and the three limits are 13-bit two's complement values with bit 12 as the sign and an LSB of 1/16 °C. Comparisons are signed, so negative samples and negative limits order correctly.
- R2: The high status bit sets when the sample is greater than the high limit. It releases when the sample is less than or equal to the high limit minus the hysteresis offset. Between those points it holds its value.
- R3: The low status bit sets when the sample is less than the low limit minus the hysteresis offset. It releases when the sample is greater than or equal to the low limit. Between those points it holds its value.
- R4: The critical status bit sets when the sample is greater than the critical limit. It releases when the sample is less than or equal to the critical limit minus the hysteresis offset. Between those points it holds its value.
- R5: The hysteresis select input sets the offset in 1/16 °C units: code 0 gives 0, 1 gives 24, 2 gives 48 and 3 gives 96.
- R6: With latchMode=0 and critOnly=0 (comparator behaviour), the alarm is asserted while any status bit is set, and a clear pulse has no effect.
- R7: With latchMode=1 and critOnly=0 (interrupt behaviour), an internal latch sets at any evaluation where the value of (high OR low) changes. The alarm is the latch OR the critical bit. A clear pulse given while the critical bit is 0 empties the latch.
- R8: In interrupt behaviour, a clear pulse given while the critical bit is 1 leaves the alarm asserted and is remembered. When an evaluation releases the critical bit, the remembered clear empties the latch.
- R9: With critOnly=1, the alarm follows the critical bit alone and clear pulses are ignored.
- R10: An evaluation happens on the clock edge where sampleValid or limitWr is high. Status bits and alarm reflect it right after that edge. Limit input changes without a strobe leave every output unchanged.
- R11: eventStatus is eventEnable AND alarm. pinPullDown is eventStatus XOR activeHigh, so a disabled output is released for active-low and pulled low for active-high.
- R12: While shutdown is 1, samples, limit-write strobes and clear pulses are ignored, so the status bits and the alarm keep their values.
- R13: After reset, all status bits, the interrupt latch and the held clear are 0, and the held sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe: sampleIn holds a new sample |
| sampleIn | input | 13 | Temperature sample, two's complement, 1/16 °C LSB |
| highLimit | input | 13 | High limit, same format, two lowest bits zero |
| lowLimit | input | 13 | Low limit, same format, two lowest bits zero |
| critLimit | input | 13 | Critical limit, same format, two lowest bits zero |
| limitWr | input | 1 | Strobe: a limit register was just written |
| hystSel | input | 2 | Hysteresis offset select |
| latchMode | input | 1 | 1 = interrupt behaviour, 0 = comparator behaviour |
| critOnly | input | 1 | 1 = alarm follows the critical bit only |
| activeHigh | input | 1 | Output polarity, 1 = active high |
| eventEnable | input | 1 | Alarm output enable |
| clearReq | input | 1 | One-cycle clear request |
| shutdown | input | 1 | Converter shut down; block state frozen |
| tripCrit | output | 1 | Critical status bit |
| tripHigh | output | 1 | High status bit |
| tripLow | output | 1 | Low status bit |
| eventStatus | output | 1 | Polarity-independent alarm state, gated by enable |
| pinPullDown | output | 1 | Pull-down enable for the open-drain alarm pin |

## Verification
The hardest case to reach is a clear that arrives while the critical bit is set and is only carried out later. The window state must not change at the critical release, or a fresh crossing would hide whether the held clear took effect. The stimulus first moves the sample from below the low limit to above the critical limit, so the window stays set without a crossing. It then clears and drops to a point above the high limit but below the critical release. Right after that evaluation the alarm must be deasserted. Sweeps that rise and fall across all three limits for every hysteresis code and two limit sets, one of them negative, pin down each release point.

// File: rtl/teg_pkg.sv
package teg_pkg;
  localparam int TEMP_W    = 13;
  localparam int HYST_W    = 2;
  localparam int HYST_BASE = 24;   // 1.5 degC in 1/16 degC units
  localparam int ZONES     = 3;
  localparam int IDX_LOW   = 0;
  localparam int IDX_HIGH  = 1;
  localparam int IDX_CRIT  = 2;

  typedef struct packed {
    logic capture;   // load the held sample
    logic evaluate;  // refresh the status bits
  } tegStrobe_t;

  typedef struct packed {
    logic crit;
    logic high;
    logic low;
  } tegZone_t;
endpackage

// File: rtl/teg_trip_cell.sv
module teg_trip_cell #(
  parameter int CW    = 14,
  parameter bit ABOVE = 1'b1
) (
  input  logic signed [CW-1:0] tempExt,
  input  logic signed [CW-1:0] limExt,
  input  logic signed [CW-1:0] hystOff,
  input  logic                 curState,
  output logic                 nextState
);
  logic signed [CW-1:0] lowered;
  logic setCond;
  logic relCond;

  assign lowered = limExt - hystOff;

  generate
    if (ABOVE) begin : g_above
      assign setCond = tempExt > limExt;
      assign relCond = tempExt <= lowered;
    end else begin : g_below
      assign setCond = tempExt < lowered;
      assign relCond = tempExt >= limExt;
    end
  endgenerate

  always_comb begin
    if (setCond)      nextState = 1'b1;
    else if (relCond) nextState = 1'b0;
    else              nextState = curState;
  end
endmodule

// File: rtl/teg_datapath.sv
module teg_datapath
  import teg_pkg::*;
#(
  parameter int TW = TEMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tegStrobe_t        stb,
  input  logic [TW-1:0]     sampleIn,
  input  logic [TW-1:0]     highLimit,
  input  logic [TW-1:0]     lowLimit,
  input  logic [TW-1:0]     critLimit,
  input  logic [HYST_W-1:0] hystSel,
  output tegZone_t          zoneNow,
  output tegZone_t          zoneNext
);
  localparam int CW = TW + 1;

  logic [TW-1:0]        tempHeld;
  logic [TW-1:0]        tempSel;
  logic signed [CW-1:0] tempExt;
  logic signed [CW-1:0] hystOff;
  logic signed [CW-1:0] limExt [ZONES];
  logic [ZONES-1:0]     curBits;
  logic [ZONES-1:0]     nxtBits;

  assign tempSel = stb.capture ? sampleIn : tempHeld;
  assign tempExt = {tempSel[TW-1], tempSel};

  assign limExt[IDX_LOW]  = {lowLimit[TW-1], lowLimit};
  assign limExt[IDX_HIGH] = {highLimit[TW-1], highLimit};
  assign limExt[IDX_CRIT] = {critLimit[TW-1], critLimit};

  always_comb begin
    hystOff = '0;
    if (hystSel != '0) hystOff = $signed(CW'(HYST_BASE << (hystSel - 1'b1)));
  end

  assign curBits  = zoneNow;
  assign zoneNext = tegZone_t'(nxtBits);

  generate
    for (genvar g = 0; g < ZONES; g++) begin : g_cell
      teg_trip_cell #(
        .CW   (CW),
        .ABOVE(g != IDX_LOW)
      ) u_cell (
        .tempExt  (tempExt),
        .limExt   (limExt[g]),
        .hystOff  (hystOff),
        .curState (curBits[g]),
        .nextState(nxtBits[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempHeld <= '0;
      zoneNow  <= '0;
    end else begin
      if (stb.capture)  tempHeld <= sampleIn;
      if (stb.evaluate) zoneNow  <= zoneNext;
    end
  end

  AST_EVAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.evaluate |=> $stable(zoneNow)); // R10
  AST_HIGH_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.evaluate && (tempExt > limExt[IDX_HIGH]) |=> zoneNow.high); // R2
  AST_LOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.evaluate && (tempExt < (limExt[IDX_LOW] - hystOff)) |=> zoneNow.low); // R3
  AST_CRIT_REL: assert property (@(posedge clk) disable iff (!rstN)
    stb.evaluate && (tempExt <= (limExt[IDX_CRIT] - hystOff)) |=> !zoneNow.crit); // R4
endmodule

// File: rtl/teg_control.sv
module teg_control
  import teg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       limitWr,
  input  logic       shutdown,
  input  logic       latchMode,
  input  logic       critOnly,
  input  logic       clearReq,
  input  logic       eventEnable,
  input  logic       activeHigh,
  input  tegZone_t   zoneNow,
  input  tegZone_t   zoneNext,
  output tegStrobe_t stb,
  output logic       eventStatus,
  output logic       pinPullDown
);
  logic intMode;
  logic winCur;
  logic winNxt;
  logic crossing;
  logic critRel;
  logic clrOk;
  logic latchQ;
  logic latchN;
  logic pendQ;
  logic pendN;
  logic asserted;

  assign stb.capture  = sampleValid & ~shutdown;
  assign stb.evaluate = (sampleValid | limitWr) & ~shutdown;

  assign intMode  = latchMode & ~critOnly;
  assign winCur   = zoneNow.high | zoneNow.low;
  assign winNxt   = zoneNext.high | zoneNext.low;
  assign crossing = stb.evaluate & (winCur != winNxt);
  assign critRel  = stb.evaluate & zoneNow.crit & ~zoneNext.crit;
  assign clrOk    = clearReq & ~shutdown;

  always_comb begin
    latchN = 1'b0;
    pendN  = 1'b0;
    if (intMode) begin
      latchN = latchQ | crossing;
      pendN  = pendQ;
      if (pendQ && critRel) begin
        latchN = crossing;
        pendN  = 1'b0;
      end
      if (clrOk) begin
        if (zoneNow.crit) pendN  = 1'b1;
        else              latchN = crossing;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      latchQ <= latchN;
      pendQ  <= pendN;
    end
  end

  always_comb begin
    if (critOnly)     asserted = zoneNow.crit;
    else if (intMode) asserted = latchQ | zoneNow.crit;
    else              asserted = winCur | zoneNow.crit;
  end

  assign eventStatus = eventEnable & asserted;
  assign pinPullDown = eventStatus ^ activeHigh;

  AST_CRIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    intMode && zoneNow.crit |-> asserted); // R8
  AST_PEND_CRIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(zoneNow.crit)); // R8
  AST_COMP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !latchMode && !critOnly && clearReq && !stb.evaluate |=> $stable(winCur)); // R6
  AST_SHDN_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    shutdown && intMode |=> $stable(latchQ)); // R12
  AST_CRITONLY_NOLATCH: assert property (@(posedge clk) disable iff (!rstN)
    critOnly |=> !latchQ && !pendQ); // R9
endmodule

// File: rtl/tempEventGen.sv
module tempEventGen
  import teg_pkg::*;
#(
  parameter int TW = TEMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TW-1:0]     sampleIn,
  input  logic [TW-1:0]     highLimit,
  input  logic [TW-1:0]     lowLimit,
  input  logic [TW-1:0]     critLimit,
  input  logic              limitWr,
  input  logic [HYST_W-1:0] hystSel,
  input  logic              latchMode,
  input  logic              critOnly,
  input  logic              activeHigh,
  input  logic              eventEnable,
  input  logic              clearReq,
  input  logic              shutdown,
  output logic              tripCrit,
  output logic              tripHigh,
  output logic              tripLow,
  output logic              eventStatus,
  output logic              pinPullDown
);
  tegStrobe_t stb;
  tegZone_t   zoneNow;
  tegZone_t   zoneNext;

  teg_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .limitWr    (limitWr),
    .shutdown   (shutdown),
    .latchMode  (latchMode),
    .critOnly   (critOnly),
    .clearReq   (clearReq),
    .eventEnable(eventEnable),
    .activeHigh (activeHigh),
    .zoneNow    (zoneNow),
    .zoneNext   (zoneNext),
    .stb        (stb),
    .eventStatus(eventStatus),
    .pinPullDown(pinPullDown)
  );

  teg_datapath #(.TW(TW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sampleIn (sampleIn),
    .highLimit(highLimit),
    .lowLimit (lowLimit),
    .critLimit(critLimit),
    .hystSel  (hystSel),
    .zoneNow  (zoneNow),
    .zoneNext (zoneNext)
  );

  assign tripCrit = zoneNow.crit;
  assign tripHigh = zoneNow.high;
  assign tripLow  = zoneNow.low;

  AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !eventEnable |-> (pinPullDown == activeHigh) && !eventStatus); // R11
  AST_SHDN_TRIPS: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> $stable({tripCrit, tripHigh, tripLow})); // R12
endmodule

// File: tb/tempEventGen_tb_top.sv
module tempEventGen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [12:0] sampleIn = '0;
  logic [12:0] highLimit = '0;
  logic [12:0] lowLimit = '0;
  logic [12:0] critLimit = '0;
  logic        limitWr = 1'b0;
  logic [1:0]  hystSel = '0;
  logic        latchMode = 1'b0;
  logic        critOnly = 1'b0;
  logic        activeHigh = 1'b0;
  logic        eventEnable = 1'b0;
  logic        clearReq = 1'b0;
  logic        shutdown = 1'b0;
  logic        tripCrit, tripHigh, tripLow, eventStatus, pinPullDown;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  tempEventGen dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .highLimit(highLimit), .lowLimit(lowLimit), .critLimit(critLimit),
    .limitWr(limitWr), .hystSel(hystSel), .latchMode(latchMode),
    .critOnly(critOnly), .activeHigh(activeHigh), .eventEnable(eventEnable),
    .clearReq(clearReq), .shutdown(shutdown), .tripCrit(tripCrit),
    .tripHigh(tripHigh), .tripLow(tripLow), .eventStatus(eventStatus),
    .pinPullDown(pinPullDown)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      failures++;
      $display("FAIL R13 watchdog expired actual=%0d expected<=200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic putSample(input int t);
    @(negedge clk);
    sampleIn = 13'(t);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
  endtask

  task automatic pulseLimit();
    @(negedge clk);
    limitWr = 1'b1;
    @(negedge clk);
    limitWr = 1'b0;
  endtask

  task automatic setLimits(input int th, input int tl, input int tc);
    highLimit = 13'(th);
    lowLimit  = 13'(tl);
    critLimit = 13'(tc);
  endtask

  function automatic int nextAbove(input int cur, input int t, input int lim, input int h);
    if (t > lim) return 1;
    if (t <= lim - h) return 0;
    return cur;
  endfunction

  function automatic int nextBelow(input int cur, input int t, input int lim, input int h);
    if (t < lim - h) return 1;
    if (t >= lim) return 0;
    return cur;
  endfunction

  initial begin
    int eH, eL, eC, h, th, tl, tc, t, st;
    eH = 0; eL = 0; eC = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 reset trips", {tripCrit, tripHigh, tripLow}, 0);
    check("R13 reset status", eventStatus, 0);
    check("R13 reset pin", pinPullDown, 0);

    // Sweeps in comparator mode: R1..R6, R11
    eventEnable = 1'b1;
    for (int ls = 0; ls < 2; ls++) begin
      if (ls == 0) begin th = 400; tl = 160; tc = 800; end
      else begin th = -32; tl = -128; tc = 160; end
      setLimits(th, tl, tc);
      activeHigh = ls[0];
      for (int hs = 0; hs < 4; hs++) begin
        hystSel = 2'(hs);
        h = (hs == 0) ? 0 : (24 << (hs - 1));
        for (int dir = 0; dir < 2; dir++) begin
          for (int k = 0; k < 184; k++) begin
            t = (dir == 0) ? (-700 + 9 * k) : (950 - 9 * k);
            eH = nextAbove(eH, t, th, h);
            eC = nextAbove(eC, t, tc, h);
            eL = nextBelow(eL, t, tl, h);
            putSample(t);
            check("R1 R2 R3 R4 R5 trip bits", {tripCrit, tripHigh, tripLow}, {eC[0], eH[0], eL[0]});
            st = eH | eL | eC;
            check("R6 comparator alarm", eventStatus, st);
            check("R11 pin polarity", pinPullDown, st ^ ls);
          end
        end
      end
    end

    // R11 disabled output levels
    putSample(500);
    eventEnable = 1'b0; activeHigh = 1'b1;
    @(negedge clk);
    check("R11 disabled active-high status", eventStatus, 0);
    check("R11 disabled active-high pin", pinPullDown, 1);
    activeHigh = 1'b0;
    @(negedge clk);
    check("R11 disabled active-low pin", pinPullDown, 0);
    eventEnable = 1'b1; activeHigh = 1'b1;
    @(negedge clk);
    check("R11 enabled active-high pin", pinPullDown, 0);
    activeHigh = 1'b0;

    // R6 clear ignored in comparator mode
    setLimits(400, 160, 800); hystSel = 2'd0;
    putSample(500);
    pulseClear();
    check("R6 clear ignored", eventStatus, 1);

    // R10 limit-write re-evaluation
    putSample(300);
    check("R10 start inside", {tripCrit, tripHigh, tripLow}, 0);
    highLimit = 13'(240);
    repeat (3) @(negedge clk);
    check("R10 limit change without strobe", tripHigh, 0);
    check("R10 alarm without strobe", eventStatus, 0);
    pulseLimit();
    check("R10 limit strobe sets high", tripHigh, 1);
    check("R10 limit strobe alarm", eventStatus, 1);
    highLimit = 13'(400);
    pulseLimit();
    check("R10 limit strobe releases high", tripHigh, 0);

    // R7 interrupt behaviour
    latchMode = 1'b1;
    @(negedge clk);
    check("R7 interrupt idle", eventStatus, 0);
    putSample(500);
    check("R7 crossing up latches", eventStatus, 1);
    putSample(300);
    check("R7 crossing back keeps", eventStatus, 1);
    pulseClear();
    check("R7 clear empties latch", eventStatus, 0);
    putSample(310);
    check("R7 no crossing stays clear", eventStatus, 0);
    putSample(100);
    check("R7 crossing low latches", eventStatus, 1);
    pulseClear();
    check("R7 clear after low", eventStatus, 0);

    // R8 clear while critical is held
    putSample(900);
    check("R8 critical asserts", eventStatus, 1);
    check("R8 critical bit", tripCrit, 1);
    pulseClear();
    check("R8 clear held above critical", eventStatus, 1);
    putSample(600);
    check("R8 held clear executes on release", eventStatus, 0);
    check("R8 high still set", tripHigh, 1);
    putSample(300);
    putSample(900);
    putSample(600);
    check("R8 no held clear keeps latch", eventStatus, 1);
    pulseClear();
    check("R8 direct clear below critical", eventStatus, 0);

    // R9 critical-only behaviour
    critOnly = 1'b1;
    putSample(500);
    check("R9 above high only", eventStatus, 0);
    putSample(900);
    check("R9 above critical", eventStatus, 1);
    pulseClear();
    check("R9 clear ignored", eventStatus, 1);
    putSample(600);
    check("R9 released", eventStatus, 0);
    critOnly = 1'b0;

    // R12 shutdown freeze (interrupt behaviour)
    putSample(300);
    pulseClear();
    putSample(500);
    putSample(300);
    check("R12 latch set before shutdown", eventStatus, 1);
    shutdown = 1'b1;
    pulseClear();
    check("R12 clear ignored in shutdown", eventStatus, 1);
    putSample(900);
    check("R12 sample ignored trips", {tripCrit, tripHigh, tripLow}, 0);
    highLimit = 13'(240);
    pulseLimit();
    check("R12 limit strobe ignored", tripHigh, 0);
    check("R12 alarm frozen", eventStatus, 1);
    shutdown = 1'b0;
    highLimit = 13'(400);
    pulseClear();
    check("R7 clear after shutdown", eventStatus, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule